// File: doc/BRIEF.md
# Program Fetch Bus Controller

This block stands between a CPU's 16-bit instruction fetch request and two code sources: an on-chip code ROM, and an external code memory reached over a multiplexed bus. For every fetch it decides where the byte comes from. The decision uses a strap input that enables the on-chip ROM and a size select that places the top of that ROM at 4K, 8K or 16K bytes. Addresses below the top go to the ROM. All other addresses use the external bus.

An external fetch runs a fixed sequence, one clock per phase. First the low address byte goes out on a shared address/data port while an address-latch strobe is high. Next that strobe falls so an outside latch keeps the byte. Then the shared port is released and an active-low code-read strobe is asserted for two cycles. The returned byte is captured at the end of the second of those cycles. During the whole sequence the high address byte sits on its own port. The shared port is modelled as separate out, in and output-enable signals.

The CPU side holds `fetch_valid` and `fetch_addr` and waits for a one-cycle `fetch_ready` pulse with the byte on `fetch_data`. A request is taken only when the controller is idle.

Top module: `ext_fetch_ctrl`

## Requirements
- R1: With `ext_strap` low, every fetch takes the external sequence, whatever `rom_sel` holds.
- R2: With `ext_strap` high, `rom_sel` sets the ROM top: 0 gives 1000h, 1 gives 2000h, 2 gives 4000h, and 3 gives no ROM. An address below the top is internal. Any other address is external.
- R3: An internal fetch raises `fetch_ready` in the cycle after acceptance, with `fetch_data` equal to `irom_rdata` for that address. During that fetch `psen_n` stays 1, and `ale` and `ad_oe` stay 0.
- R4: In the cycle after an external fetch is accepted, `ale`=1, `ad_oe`=1 and `ad_out` carries address bits [7:0].
- R5: From that first cycle through the capture cycle, `addr_hi` carries address bits [15:8].
- R6: In the second cycle of an external fetch, `ale`=0 while `ad_oe`=1 and `ad_out` still carries the low address byte.
- R7: In the third and fourth cycles of an external fetch, `ad_oe`=0 and `psen_n`=0.
- R8: The byte present on `ad_in` at the end of the fourth cycle appears on `fetch_data`, with `fetch_ready`=1, in the fifth cycle after acceptance.
- R9: `fetch_ready` lasts exactly one cycle. A change to `fetch_addr` while a fetch is in progress has no effect on that fetch.
- R10: While reset is active and after it, until a fetch is accepted, `psen_n`=1, `ale`=0, `ad_oe`=0 and `fetch_ready`=0. Reset in the middle of a sequence ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | CPU fetch request |
| fetch_addr | input | 16 | Fetch address |
| fetch_ready | output | 1 | One-cycle pulse: fetch_data is valid |
| fetch_data | output | 8 | Fetched code byte |
| ext_strap | input | 1 | 1 enables the on-chip ROM |
| rom_sel | input | 2 | On-chip ROM size select |
| irom_addr | output | 16 | Address to the on-chip ROM |
| irom_rdata | input | 8 | Combinational read data from the on-chip ROM |
| ad_out | output | 8 | Shared port, outgoing low address byte |
| ad_in | input | 8 | Shared port, incoming code byte |
| ad_oe | output | 1 | Shared port output enable |
| addr_hi | output | 8 | High address byte port |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |

## Verification
Two things can fall in the same cycle: the capture of a byte from the shared port, and the arrival of a changed request from the CPU while the sequence is still running. The bench provokes this by keeping `fetch_valid` high, changing `fetch_addr` during the latch and capture phases, and changing `ad_in` just after the capture edge. It then requires that the port bytes and the delivered data still belong to the original fetch. It also requires that the changed request starts only after the ready pulse has ended.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_LATCH  = 3'd2,
        PH_STROBE = 3'd3,
        PH_SAMPLE = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

    typedef struct packed {
        logic ale;
        logic ad_oe;
        logic psen_n;
        logic ready;
    } bus_drive_t;

    function automatic bus_drive_t drive_of(phase_e p);
        bus_drive_t d;
        d.ale    = (p == PH_ADDR);
        d.ad_oe  = (p == PH_ADDR) || (p == PH_LATCH);
        d.psen_n = !((p == PH_STROBE) || (p == PH_SAMPLE));
        d.ready  = (p == PH_DONE);
        return d;
    endfunction

endpackage

// File: rtl/fbc_route.sv
module fbc_route #(
    parameter int ADDR_W        = 16,
    parameter int ROM_BASE_LOG2 = 12
) (
    input  logic              ext_strap,
    input  logic [1:0]        rom_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_internal
);
    localparam int LIM_W = ADDR_W + 1;

    logic [LIM_W-1:0] limit;

    always_comb begin
        if (rom_sel == 2'd3)
            limit = '0;
        else
            limit = {{(LIM_W-1){1'b0}}, 1'b1} << (ROM_BASE_LOG2 + int'(rom_sel));
        is_internal = ext_strap && ({1'b0, addr} < limit);
    end
endmodule

// File: rtl/fbc_seq.sv
module fbc_seq
    import fbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  logic   internal,
    output phase_e phase,
    output logic   accept
);
    phase_e nxt;

    assign accept = (phase == PH_IDLE) && req;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:   if (req) nxt = internal ? PH_DONE : PH_ADDR;
            PH_ADDR:   nxt = PH_LATCH;
            PH_LATCH:  nxt = PH_STROBE;
            PH_STROBE: nxt = PH_SAMPLE;
            PH_SAMPLE: nxt = PH_DONE;
            PH_DONE:   nxt = PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    // R9: an accepted request always leaves idle
    assert_accept_leaves_idle_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> phase != PH_IDLE);
endmodule

// File: rtl/fbc_capture.sv
module fbc_capture
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              internal,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] irom_rdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] lo_q,
    output logic [ADDR_W-DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int HI_W = ADDR_W - DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                lo_q <= addr_in[DATA_W-1:0];
                if (internal) data_q <= irom_rdata;
                else          hi_q   <= addr_in[ADDR_W-1 -: HI_W];
            end
            if (phase == PH_SAMPLE) data_q <= ad_in;
        end
    end
endmodule

// File: rtl/ext_fetch_ctrl.sv
module ext_fetch_ctrl
    import fbc_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int ROM_BASE_LOG2 = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_valid,
    input  logic [ADDR_W-1:0]        fetch_addr,
    output logic                     fetch_ready,
    output logic [DATA_W-1:0]        fetch_data,
    input  logic                     ext_strap,
    input  logic [1:0]               rom_sel,
    output logic [ADDR_W-1:0]        irom_addr,
    input  logic [DATA_W-1:0]        irom_rdata,
    output logic [DATA_W-1:0]        ad_out,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     psen_n
);
    logic       is_internal;
    logic       accept;
    phase_e     phase;
    bus_drive_t drv;

    fbc_route #(.ADDR_W(ADDR_W), .ROM_BASE_LOG2(ROM_BASE_LOG2)) u_route (
        .ext_strap  (ext_strap),
        .rom_sel    (rom_sel),
        .addr       (fetch_addr),
        .is_internal(is_internal)
    );

    fbc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (fetch_valid),
        .internal(is_internal),
        .phase   (phase),
        .accept  (accept)
    );

    fbc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .internal  (is_internal),
        .phase     (phase),
        .addr_in   (fetch_addr),
        .irom_rdata(irom_rdata),
        .ad_in     (ad_in),
        .lo_q      (ad_out),
        .hi_q      (addr_hi),
        .data_q    (fetch_data)
    );

    assign irom_addr   = fetch_addr;
    assign drv         = drive_of(phase);
    assign ale         = drv.ale;
    assign ad_oe       = drv.ad_oe;
    assign psen_n      = drv.psen_n;
    assign fetch_ready = drv.ready;

    // R3: an internal fetch finishes next cycle with no code-read strobe
    assert_int_fetch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && is_internal) |=> (fetch_ready && psen_n && !ale));

    // R6: the latch strobe falls while the low byte is still driven
    assert_ale_falls_R6: assert property (@(posedge clk) disable iff (rst)
        ale |=> (!ale && ad_oe && $stable(ad_out)));

    // R5: high byte holds across the address phases
    assert_hi_stable_R5: assert property (@(posedge clk) disable iff (rst)
        ale |=> $stable(addr_hi));

    // R7: the shared port never drives while the code-read strobe is low
    assert_port_float_R7: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !ad_oe);

    // R9: ready is a single-cycle pulse
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        fetch_ready |=> !fetch_ready);
endmodule

// File: tb/sim_ext_fetch_ctrl.sv
module sim_ext_fetch_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [7:0]  fetch_data;
    logic        ext_strap = 1'b0;
    logic [1:0]  rom_sel = '0;
    logic [15:0] irom_addr;
    logic [7:0]  irom_rdata;
    logic [7:0]  ad_out;
    logic [7:0]  ad_in = '0;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale;
    logic        psen_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    // on-chip ROM model: content derived from address
    assign irom_rdata = irom_addr[7:0] ^ irom_addr[15:8] ^ 8'h5A;

    ext_fetch_ctrl u0 (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data), .ext_strap(ext_strap),
        .rom_sel(rom_sel), .irom_addr(irom_addr), .irom_rdata(irom_rdata),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ale(ale), .psen_n(psen_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    // {strap, rom_sel, addr, ext byte, expect internal}
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 2'd0, 16'h0FFF, 8'h11, 1'b1},
        {1'b1, 2'd0, 16'h1000, 8'h22, 1'b0},
        {1'b1, 2'd1, 16'h1FFF, 8'h33, 1'b1},
        {1'b1, 2'd1, 16'h2000, 8'h44, 1'b0},
        {1'b1, 2'd2, 16'h3FFF, 8'h55, 1'b1},
        {1'b1, 2'd2, 16'h4000, 8'h66, 1'b0},
        {1'b0, 2'd2, 16'h0000, 8'h77, 1'b0},
        {1'b1, 2'd3, 16'h0005, 8'h88, 1'b0},
        {1'b0, 2'd0, 16'hABCD, 8'h99, 1'b0},
        {1'b1, 2'd0, 16'h0000, 8'hAA, 1'b1}
    };

    task automatic run_fetch(input logic strap, input logic [1:0] sel,
                             input logic [15:0] a, input logic [7:0] xb,
                             input logic exp_int, input string rq);
        logic [7:0] ib;
        ib = a[7:0] ^ a[15:8] ^ 8'h5A;
        @(negedge clk);
        ext_strap = strap; rom_sel = sel; fetch_addr = a; fetch_valid = 1'b1;
        @(negedge clk);
        fetch_valid = 1'b0;
        if (exp_int) begin
            chk(fetch_ready && fetch_data == ib, rq, "R3 internal data", fetch_data, ib);
            chk(psen_n && !ale && !ad_oe, rq, "R3 internal no bus",
                {psen_n, ale, ad_oe}, 3'b100);
        end else begin
            chk(ale && ad_oe && ad_out == a[7:0] && !fetch_ready, rq, "R4 addr phase",
                {ale, ad_oe, ad_out}, {2'b11, a[7:0]});
            chk(addr_hi == a[15:8], rq, "R5 hi in addr phase", addr_hi, a[15:8]);
            @(negedge clk);
            chk(!ale && ad_oe && ad_out == a[7:0] && psen_n, "R6", "latch phase",
                {ale, ad_oe, ad_out}, {2'b01, a[7:0]});
            @(negedge clk);
            chk(!ad_oe && !psen_n, "R7", "strobe phase", {ad_oe, psen_n}, 0);
            ad_in = xb;
            @(negedge clk);
            chk(!ad_oe && !psen_n && addr_hi == a[15:8], "R7", "sample phase",
                {ad_oe, psen_n, addr_hi}, {2'b00, a[15:8]});
            @(negedge clk);
            chk(fetch_ready && fetch_data == xb && psen_n, "R8", "ext data",
                fetch_data, xb);
        end
        @(negedge clk);
        chk(!fetch_ready, "R9", "ready one cycle", fetch_ready, 0);
    endtask

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        chk(psen_n && !ale && !ad_oe && !fetch_ready, "R10", "in reset",
            {psen_n, ale, ad_oe, fetch_ready}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(psen_n && !ale && !ad_oe && !fetch_ready, "R10", "after reset idle",
            {psen_n, ale, ad_oe, fetch_ready}, 4'b1000);

        // R1 / R2 routing table
        for (int i = 0; i < NV; i++) begin
            run_fetch(VEC[i][27], VEC[i][26:25], VEC[i][24:9], VEC[i][8:1], VEC[i][0],
                      VEC[i][27] ? "R2" : "R1");
        end

        // R9: address changes during a running fetch, valid held high
        @(negedge clk);
        ext_strap = 1'b0; fetch_addr = 16'h5A3C; fetch_valid = 1'b1;
        @(negedge clk);                 // ADDR
        fetch_addr = 16'h0102;
        @(negedge clk);                 // LATCH
        chk(ad_out == 8'h3C && addr_hi == 8'h5A, "R9", "addr change ignored",
            {addr_hi, ad_out}, 16'h5A3C);
        fetch_addr = 16'hF0E1;
        @(negedge clk);                 // STROBE
        ad_in = 8'hC3;
        @(negedge clk);                 // SAMPLE
        fetch_addr = 16'h7788;
        ad_in = 8'h00;                  // after capture edge? no: capture at next edge
        ad_in = 8'hC3;
        @(negedge clk);                 // DONE
        ad_in = 8'h3F;
        chk(fetch_ready && fetch_data == 8'hC3, "R9", "data of original fetch",
            fetch_data, 8'hC3);
        @(negedge clk);                 // IDLE, new request taken at next edge
        chk(!fetch_ready && !ale, "R9", "ready ended before new fetch",
            {fetch_ready, ale}, 0);
        @(negedge clk);                 // ADDR of new request
        fetch_valid = 1'b0;
        chk(ale && ad_out == 8'h88 && addr_hi == 8'h77 && fetch_data == 8'hC3,
            "R9", "new fetch starts after", {addr_hi, ad_out}, 16'h7788);

        // R10: reset in the middle of a sequence
        @(negedge clk);                 // LATCH
        @(negedge clk);                 // STROBE
        chk(!psen_n, "R7", "strobe before reset", psen_n, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(psen_n && !ad_oe && !ale && !fetch_ready, "R10", "reset aborts fetch",
            {psen_n, ale, ad_oe, fetch_ready}, 4'b1000);
        @(negedge clk);
        chk(psen_n && !fetch_ready, "R10", "stays idle", {psen_n, fetch_ready}, 2'b10);

        finish_run();
    end
endmodule